// File: doc/BRIEF.md
# Fast PWM Timer with Selectable, Buffered TOP

This block is a 16-bit up-counter with single-slope PWM waveform generation. It has two compare channels, A and B. The counter moves forward only on cycles where an external prescaler pulses `tick_i`. When the count equals the current TOP value, the counter returns to zero on that same tick. TOP is taken from one of three sources: a fixed all-ones value, an unbuffered capture-style register, or the active value of compare channel A.

Software-side writes arrive through a small write port. The compare channels hold each write in a buffer and copy it into the active register at the TOP tick, so a PWM period never sees a half-applied setting. The capture register has no such buffer. Lowering it below the running count makes the counter miss TOP, run on to 0xFFFF and wrap to zero before it can match.

Each channel drives one PWM output whose polarity is selected by a 2-bit mode. Four sticky flags report overflow, compare matches and the capture-register TOP event.

Top module: `fpwm_timer`

## Requirements
- R1: The count changes only on cycles where `tick_i` is 1. On each such cycle it becomes either count+1 (modulo 2^16) or 0.
- R2: On a tick while the count equals TOP, the count becomes 0 and the overflow flag (`flags_o[0]`) is set.
- R3: With `top_src_i`=0 (fixed), `fix_sel_i` 0 gives TOP 0x00FF, 1 gives 0x01FF, and 2 or 3 give 0x03FF. `top_src_i`=3 behaves like 0.
- R4: With `top_src_i`=2, TOP is the active value of compare A. A write to address 0 reaches only A's buffer, and the buffer is copied to the active register on the TOP tick. On that tick the compare-A flag (`flags_o[1]`) is set together with the overflow flag.
- R5: With `top_src_i`=1, TOP is the capture register (address 2), which takes a write at once. On the TOP tick the capture flag (`flags_o[3]`) is set. If the register is written below the current count, the counter runs to 0xFFFF and wraps to 0 without setting the overflow flag.
- R6: On a tick where the count equals a channel's active compare value, that channel's flag is set (A: `flags_o[1]`, B: `flags_o[2]`). A compare value above TOP never produces a match.
- R7: Output mode 2 drives the channel level: high from the TOP-to-0 tick until the tick after a match. If the match and TOP fall on the same tick, the output stays high. Mode 3 drives the complement of that level. Modes 0 and 1 drive 0.
- R8: Compare B (address 1) is buffered like A: a write takes effect only from the next TOP tick.
- R9: While a fixed TOP is selected, bits of a compare-register write above the TOP width are stored as 0.
- R10: Flags are sticky. Writing 1 to a bit of `flag_clr_i` clears that flag and leaves the other flags as they are. A set event in the same cycle wins over the clear.
- R11: After reset the count, every flag, every compare register and the capture register are 0, and both PWM outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler, one cycle wide |
| top_src_i | input | 2 | TOP source: 0 fixed, 1 capture register, 2 compare A, 3 fixed |
| fix_sel_i | input | 2 | Fixed TOP choice: 0x00FF, 0x01FF, 0x03FF, 0x03FF |
| mode_a_i | input | 2 | Output mode of channel A |
| mode_b_i | input | 2 | Output mode of channel B |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 compare A, 1 compare B, 2 capture, 3 unused |
| wr_data_i | input | 16 | Write data |
| flag_clr_i | input | 4 | Flag clear, write 1 to clear |
| count_o | output | 16 | Current count |
| flags_o | output | 4 | Flags: 0 overflow, 1 compare A, 2 compare B, 3 capture TOP |
| pwm_a_o | output | 1 | PWM output of channel A |
| pwm_b_o | output | 1 | PWM output of channel B |

## Verification
The fixed TOP is tried at every `fix_sel_i` value. Counting to exactly TOP and then taking one more tick tells the wrap point apart from an off-by-one. The buffered compare registers are rewritten in mid-period to a value the counter has already passed or has not yet reached. This shows whether the new value acts at once or only after TOP. The capture register is rewritten both above and below the running count, which separates a prompt TOP change from the full 0xFFFF overshoot. Further scenarios cover a 16-bit compare write under the smallest fixed TOP, a compare value above TOP, and a flag clear that coincides with a set event.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic [1:0] {
    TOP_FIXED = 2'd0,
    TOP_CAPT  = 2'd1,
    TOP_CMPA  = 2'd2,
    TOP_RSVD  = 2'd3
  } top_src_e;

  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned NUM_FLAG = 4;

  localparam int unsigned FLAG_OVF  = 0;
  localparam int unsigned FLAG_CMPA = 1;
  localparam int unsigned FLAG_CMPB = 2;
  localparam int unsigned FLAG_CAPT = 3;

  localparam logic [1:0] ADDR_CMPA = 2'd0;
  localparam logic [1:0] ADDR_CMPB = 2'd1;
  localparam logic [1:0] ADDR_CAPT = 2'd2;

  localparam logic [1:0] MODE_NONINV = 2'd2;
  localparam logic [1:0] MODE_INV    = 2'd3;
endpackage

// File: rtl/fpwm_top_sel.sv
module fpwm_top_sel
  import fpwm_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FIX_BASE_W = 8
) (
  input  logic [1:0]       top_src_i,
  input  logic [1:0]       fix_sel_i,
  input  logic [CNT_W-1:0] capt_val_i,
  input  logic [CNT_W-1:0] cmpa_act_i,
  output logic [CNT_W-1:0] top_val_o,
  output logic [CNT_W-1:0] wr_mask_o
);
  localparam int unsigned MAX_STEP = 2;

  logic [1:0]       step;
  logic [CNT_W-1:0] fixed_top;

  always_comb begin
    step      = (fix_sel_i > 2'(MAX_STEP)) ? 2'(MAX_STEP) : fix_sel_i;
    fixed_top = {CNT_W{1'b1}} >> (CNT_W - FIX_BASE_W - step);
  end

  always_comb begin
    unique case (top_src_e'(top_src_i))
      TOP_CAPT: begin
        top_val_o = capt_val_i;
        wr_mask_o = '1;
      end
      TOP_CMPA: begin
        top_val_o = cmpa_act_i;
        wr_mask_o = '1;
      end
      default: begin
        top_val_o = fixed_top;
        wr_mask_o = fixed_top;
      end
    endcase
  end
endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  // exact equality: a TOP below the count is passed over until rollover
  assign wrap_o = tick_i && (cnt_o == top_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (tick_i) begin
      cnt_o <= wrap_o ? '0 : cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/fpwm_chan.sv
module fpwm_chan
  import fpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] act_o,
  output logic             match_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] buf_q;
  logic             lvl_q;

  assign match_o = tick_i && (cnt_i == act_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
    end else if (wr_i) begin
      buf_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= '0;
    end else if (wrap_i) begin
      act_o <= buf_q;
    end
  end

  // wrap sets, match clears; wrap wins when both fall on one tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else if (wrap_i) begin
      lvl_q <= 1'b1;
    end else if (match_o) begin
      lvl_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_NONINV: pwm_o = lvl_q;
      MODE_INV:    pwm_o = ~lvl_q;
      default:     pwm_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FIX_BASE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       top_src_i,
  input  logic [1:0]       fix_sel_i,
  input  logic [1:0]       mode_a_i,
  input  logic [1:0]       mode_b_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [3:0]       flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [3:0]       flags_o,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);
  logic [CNT_W-1:0] capt_q;
  logic [CNT_W-1:0] top_val;
  logic [CNT_W-1:0] wr_mask;
  logic             wrap;

  logic [CNT_W-1:0] ch_act   [NUM_CH];
  logic             ch_match [NUM_CH];
  logic             ch_pwm   [NUM_CH];
  logic [1:0]       ch_mode  [NUM_CH];
  logic [1:0]       ch_addr  [NUM_CH];

  logic [NUM_FLAG-1:0] flag_set;

  assign ch_mode[0] = mode_a_i;
  assign ch_mode[1] = mode_b_i;
  assign ch_addr[0] = ADDR_CMPA;
  assign ch_addr[1] = ADDR_CMPB;

  fpwm_top_sel #(
    .CNT_W     (CNT_W),
    .FIX_BASE_W(FIX_BASE_W)
  ) i_top_sel (
    .top_src_i (top_src_i),
    .fix_sel_i (fix_sel_i),
    .capt_val_i(capt_q),
    .cmpa_act_i(ch_act[0]),
    .top_val_o (top_val),
    .wr_mask_o (wr_mask)
  );

  fpwm_counter #(
    .CNT_W(CNT_W)
  ) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .top_val_i(top_val),
    .cnt_o    (count_o),
    .wrap_o   (wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fpwm_chan #(
      .CNT_W(CNT_W)
    ) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .wrap_i   (wrap),
      .cnt_i    (count_o),
      .wr_i     (wr_en_i && (wr_addr_i == ch_addr[c])),
      .wr_data_i(wr_data_i & wr_mask),
      .mode_i   (ch_mode[c]),
      .act_o    (ch_act[c]),
      .match_o  (ch_match[c]),
      .pwm_o    (ch_pwm[c])
    );
  end

  assign pwm_a_o = ch_pwm[0];
  assign pwm_b_o = ch_pwm[1];

  // capture-style TOP register: unbuffered, unmasked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      capt_q <= '0;
    end else if (wr_en_i && wr_addr_i == ADDR_CAPT) begin
      capt_q <= wr_data_i;
    end
  end

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_OVF]  = wrap;
    flag_set[FLAG_CMPA] = ch_match[0];
    flag_set[FLAG_CMPB] = ch_match[1];
    flag_set[FLAG_CAPT] = wrap && (top_src_e'(top_src_i) == TOP_CAPT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
    end else begin
      flags_o <= (flags_o & ~flag_clr_i) | flag_set;
    end
  end
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       top_src_i,
  input logic [1:0]       mode_a_i,
  input logic [1:0]       mode_b_i,
  input logic [3:0]       flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic [3:0]       flags_o,
  input logic             pwm_a_o,
  input logic             pwm_b_o,
  input logic [CNT_W-1:0] top_val
);
  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (count_o == '0) || (count_o == $past(count_o) + 1'b1));

  // R2
  top_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == top_val) |=> (count_o == '0) && flags_o[0]);

  // R4
  cmpa_top_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == top_val && top_src_i == 2'd2) |=> flags_o[1]);

  // R5
  capt_top_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == top_val && top_src_i == 2'd1) |=> flags_o[3]);

  // R7
  pwm_a_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_a_i[1] |-> !pwm_a_o);

  // R7
  pwm_b_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_b_i[1] |-> !pwm_b_o);

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & $past(flags_o & ~flag_clr_i)) == $past(flags_o & ~flag_clr_i)));
endmodule

bind fpwm_timer fpwm_timer_chk #(.CNT_W(CNT_W)) i_fpwm_timer_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .top_src_i (top_src_i),
  .mode_a_i  (mode_a_i),
  .mode_b_i  (mode_b_i),
  .flag_clr_i(flag_clr_i),
  .count_o   (count_o),
  .flags_o   (flags_o),
  .pwm_a_o   (pwm_a_o),
  .pwm_b_o   (pwm_b_o),
  .top_val   (top_val)
);

// File: tb/test_fpwm_timer.sv
module test_fpwm_timer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  top_src_i = 2'd0;
  logic [1:0]  fix_sel_i = 2'd0;
  logic [1:0]  mode_a_i = 2'd0;
  logic [1:0]  mode_b_i = 2'd0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [15:0] wr_data_i = '0;
  logic [3:0]  flag_clr_i = '0;
  logic [15:0] count_o;
  logic [3:0]  flags_o;
  logic        pwm_a_o;
  logic        pwm_b_o;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  fpwm_timer i_fpwm_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .top_src_i (top_src_i),
    .fix_sel_i (fix_sel_i),
    .mode_a_i  (mode_a_i),
    .mode_b_i  (mode_b_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .flag_clr_i(flag_clr_i),
    .count_o   (count_o),
    .flags_o   (flags_o),
    .pwm_a_o   (pwm_a_o),
    .pwm_b_o   (pwm_b_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0;
    wr_en_i = 1'b0;
    flag_clr_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [15:0] data);
    wr_en_i = 1'b1;
    wr_addr_i = addr;
    wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clr(input logic [3:0] m);
    flag_clr_i = m;
    @(negedge clk_i);
    flag_clr_i = '0;
  endtask

  task automatic t_reset();
    top_src_i = 2'd0; fix_sel_i = 2'd0; mode_a_i = 2'd2; mode_b_i = 2'd2;
    do_reset();
    check("R11 count", 32'(count_o), 0);
    check("R11 flags", 32'(flags_o), 0);
    check("R11 pwm_a", 32'(pwm_a_o), 0);
    check("R11 pwm_b", 32'(pwm_b_o), 0);
  endtask

  task automatic t_tick_gate();
    top_src_i = 2'd0; fix_sel_i = 2'd0; mode_a_i = 2'd0; mode_b_i = 2'd0;
    do_reset();
    repeat (5) @(negedge clk_i);
    check("R1 hold without tick", 32'(count_o), 0);
    ticks(5);
    check("R1 five ticks", 32'(count_o), 5);
    wr(2'd2, 16'h0003);
    check("R1 write does not move count", 32'(count_o), 5);
  endtask

  task automatic t_fixed_top(input logic [1:0] sel, input int top);
    top_src_i = 2'd0; fix_sel_i = sel;
    do_reset();
    ticks(top);
    check("R3 count at TOP", 32'(count_o), 32'(top));
    check("R2 no overflow before TOP", 32'(flags_o[0]), 0);
    ticks(1);
    check("R2 wrap to zero", 32'(count_o), 0);
    check("R2 overflow set", 32'(flags_o[0]), 1);
  endtask

  task automatic t_cmpa_top();
    top_src_i = 2'd2; mode_a_i = 2'd0; mode_b_i = 2'd0;
    do_reset();
    wr(2'd0, 16'h0020);
    ticks(1);
    check("R4 TOP 0 wraps", 32'(count_o), 0);
    check("R4 overflow and A flag", 32'(flags_o[1:0]), 3);
    clr(4'hF);
    ticks(16);
    wr(2'd0, 16'h0008);
    ticks(16);
    check("R4 buffered write not active", 32'(count_o), 32'h20);
    check("R4 no overflow mid-period", 32'(flags_o[0]), 0);
    ticks(1);
    check("R4 wrap at old TOP", 32'(count_o), 0);
    check("R4 A flag with overflow", 32'(flags_o[1:0]), 3);
    clr(4'hF);
    ticks(8);
    check("R4 new TOP reached", 32'(flags_o[0]), 0);
    ticks(1);
    check("R4 new TOP wraps", 32'(count_o), 0);
    check("R4 overflow at new TOP", 32'(flags_o[0]), 1);
  endtask

  task automatic t_capt_top();
    top_src_i = 2'd1; mode_a_i = 2'd0; mode_b_i = 2'd0;
    do_reset();
    wr(2'd2, 16'h0040);
    ticks(5);
    wr(2'd2, 16'h0008);
    ticks(3);
    check("R5 immediate TOP count", 32'(count_o), 8);
    check("R5 no overflow yet", 32'(flags_o[0]), 0);
    ticks(1);
    check("R5 wrap at new TOP", 32'(count_o), 0);
    check("R5 overflow and capture flag", 32'({flags_o[3], flags_o[0]}), 3);
    clr(4'hF);
    wr(2'd2, 16'h0040);
    ticks(16'h30);
    wr(2'd2, 16'h0010);
    ticks(16'hFFFF - 16'h30);
    check("R5 overshoot reaches max", 32'(count_o), 32'hFFFF);
    check("R5 no overflow during overshoot", 32'(flags_o[0]), 0);
    ticks(1);
    check("R5 rollover to zero", 32'(count_o), 0);
    check("R5 rollover sets no overflow", 32'(flags_o[0]), 0);
    ticks(16'h10);
    check("R5 no capture flag before TOP", 32'(flags_o[3]), 0);
    ticks(1);
    check("R5 match after rollover", 32'({flags_o[3], flags_o[0], count_o}), 32'h30000);
  endtask

  task automatic t_cmp_above_top();
    top_src_i = 2'd1; mode_a_i = 2'd0; mode_b_i = 2'd2;
    do_reset();
    wr(2'd2, 16'h0020);
    wr(2'd1, 16'h0030);
    ticks(16'h21);
    check("R6 capture TOP wrap", 32'(count_o), 0);
    clr(4'hF);
    ticks(66);
    check("R6 two periods done", 32'(count_o), 0);
    check("R6 B above TOP never matches", 32'(flags_o[2]), 0);
    check("R7 B stays high without match", 32'(pwm_b_o), 1);
  endtask

  task automatic t_pwm();
    top_src_i = 2'd0; fix_sel_i = 2'd0; mode_a_i = 2'd2; mode_b_i = 2'd3;
    do_reset();
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'h0010);
    ticks(256);
    check("R7 non-inverted high after TOP", 32'(pwm_a_o), 1);
    check("R7 inverted low after TOP", 32'(pwm_b_o), 0);
    ticks(16'h10);
    check("R7 high through match count", 32'(pwm_a_o), 1);
    ticks(1);
    check("R7 non-inverted low after match", 32'(pwm_a_o), 0);
    check("R7 inverted high after match", 32'(pwm_b_o), 1);
    ticks(239);
    check("R7 period end", 32'(count_o), 0);
    mode_a_i = 2'd0; mode_b_i = 2'd1;
    #1;
    check("R7 mode 0 low", 32'(pwm_a_o), 0);
    check("R7 mode 1 low", 32'(pwm_b_o), 0);
    mode_a_i = 2'd2;
    #1;
    check("R7 level restored", 32'(pwm_a_o), 1);
  endtask

  task automatic t_cmpb_buffer();
    top_src_i = 2'd0; fix_sel_i = 2'd0; mode_a_i = 2'd0; mode_b_i = 2'd2;
    do_reset();
    wr(2'd1, 16'h0010);
    ticks(256);
    ticks(16'h20);
    check("R6 B match flag", 32'(flags_o[2]), 1);
    check("R8 B low after match", 32'(pwm_b_o), 0);
    clr(4'hF);
    wr(2'd1, 16'h0080);
    ticks(16'h61);
    check("R8 new B value not yet active", 32'(flags_o[2]), 0);
    ticks(127);
    check("R8 period end", 32'(count_o), 0);
    ticks(16'h80);
    check("R8 B before new match", 32'(flags_o[2]), 0);
    ticks(1);
    check("R8 B matches new value", 32'(flags_o[2]), 1);
  endtask

  task automatic t_mask();
    top_src_i = 2'd0; fix_sel_i = 2'd0; mode_a_i = 2'd0; mode_b_i = 2'd0;
    do_reset();
    wr(2'd0, 16'h1234);
    ticks(256);
    clr(4'hF);
    ticks(16'h34);
    check("R9 no A match before masked value", 32'(flags_o[1]), 0);
    ticks(1);
    check("R9 A matches masked value 0x34", 32'(flags_o[1]), 1);
  endtask

  task automatic t_flags();
    top_src_i = 2'd0; fix_sel_i = 2'd0; mode_a_i = 2'd0; mode_b_i = 2'd0;
    do_reset();
    ticks(256);
    clr(4'hF);
    ticks(10);
    check("R10 cleared stays clear", 32'(flags_o[0]), 0);
    ticks(245);
    check("R10 count at TOP", 32'(count_o), 32'hFF);
    tick_i = 1'b1;
    flag_clr_i = 4'h1;
    @(negedge clk_i);
    tick_i = 1'b0;
    flag_clr_i = '0;
    check("R10 set wins over clear", 32'(flags_o[0]), 1);
    ticks(10);
    check("R10 sticky", 32'(flags_o[0]), 1);
    clr(4'h2);
    check("R10 other bit clear leaves overflow", 32'(flags_o[0]), 1);
    clr(4'h1);
    check("R10 clear by write 1", 32'(flags_o[0]), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_tick_gate();
    t_fixed_top(2'd0, 16'h00FF);
    t_fixed_top(2'd1, 16'h01FF);
    t_fixed_top(2'd2, 16'h03FF);
    t_fixed_top(2'd3, 16'h03FF);
    t_cmpa_top();
    t_capt_top();
    t_cmp_above_top();
    t_pwm();
    t_cmpb_buffer();
    t_mask();
    t_flags();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule